// File: doc/BRIEF.md
# Two-Way Interprocessor Word Mailbox

This block lets a host processor and a remote processor exchange 32-bit words through two independent FIFOs that run in opposite directions. The inbound queue carries words from the remote side to the host; the outbound queue carries words from the host to the remote side. The host reaches both queues through a small register window. The remote side uses a valid/ready push port into the inbound queue and a valid/ready pop port out of the outbound queue.

The host drains inbound words by reading the pop register until the inbound status shows empty. It can look at the oldest word without removing it, and it can enable a level interrupt that stays high while inbound words are waiting. The host sends a word by writing it to the outbound push register. It polls the outbound full flag to learn when there is room again. Writes that reach a full outbound queue are dropped and leave a sticky overflow flag. Reset is synchronous and active high.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty, the config enable bit is 0, `host_irq` is 0, `rmt_pop_valid` is 0 and the overflow flag is clear.
- R2: A host read with `host_ren` high at offset 0x00 returns the oldest inbound word on `host_rdata` in the cycle after the request and removes that word. Words leave in the order the remote side pushed them.
- R3: A host read of offset 0x00 while the inbound queue is empty returns 0 and leaves the queue contents unchanged.
- R4: A host read of offset 0x10 returns the oldest inbound word without removing it, and returns 0 when the inbound queue is empty.
- R5: The status register of each queue (inbound at 0x18, outbound at 0x38) has bit 31 = full and bit 30 = empty. Every other bit reads 0, except bit 0 of the outbound status, which is the overflow flag.
- R6: Config at 0x1C: bit 0 is read/write and all other bits read 0. `host_irq` is high exactly while bit 0 is 1 and the inbound queue is not empty.
- R7: A host write at offset 0x20 appends `host_wdata` to the outbound queue. `rmt_pop_valid` is high whenever that queue is not empty, `rmt_pop_data` shows its oldest word, and words leave in write order when the remote side accepts them with `rmt_pop_ready`.
- R8: Each queue holds DEPTH (default 8) words. A host write to offset 0x20 while the outbound queue is full is dropped and sets the overflow flag. The flag stays set until a host read of 0x38. That read returns the flag and then clears it.
- R9: `rmt_push_ready` is low exactly while the inbound queue is full. A push offered while it is low is not stored.
- R10: Host writes to offsets 0x00, 0x10, 0x18 and 0x38 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 6 | Host byte offset in the register window |
| host_wen | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_ren | input | 1 | Host read strobe |
| host_rdata | output | 32 | Read data, valid the cycle after `host_ren`, 0 otherwise |
| host_irq | output | 1 | Level interrupt: inbound data waiting and enabled |
| rmt_push_valid | input | 1 | Remote offers an inbound word |
| rmt_push_data | input | 32 | Inbound word |
| rmt_push_ready | output | 1 | Inbound queue can accept a word |
| rmt_pop_valid | output | 1 | Outbound word available |
| rmt_pop_data | output | 32 | Oldest outbound word |
| rmt_pop_ready | input | 1 | Remote takes the outbound word |

## Verification
On every cycle the assertions check that the occupancy never goes past DEPTH, that push ready and pop valid follow occupancy, and that the interrupt is high while enabled data waits. They also check that an empty read or a dropped write leaves occupancy unchanged and that the overflow flag holds until its clearing read. Word ordering, peek data, exact status encodings and the effect of writes to read-only offsets depend on data values. Only the directed scenarios of the bench can show those.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_IN_POP   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_IN_PEEK  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_IN_STAT  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_IN_CFG   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_OUT_PUSH = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_OUT_STAT = 6'h38;

  // status word: full in bit 31, empty in bit 30, sticky flag in bit 0
  function automatic logic [WORD_W-1:0] pack_status(logic full, logic empty, logic sticky);
    return {full, empty, {(WORD_W-3){1'b0}}, sticky};
  endfunction

  // head word, or zero when nothing is queued
  function automatic logic [WORD_W-1:0] head_or_zero(logic empty, logic [WORD_W-1:0] head);
    return empty ? '0 : head;
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  function automatic logic [PW-1:0] ptr_step(logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_step(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbox_host_regs.sv
module mbox_host_regs
  import ipc_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  input  logic              cfg_wbit,
  input  logic              ren,
  input  logic [WORD_W-1:0] in_head,
  input  logic              in_full,
  input  logic              in_empty,
  input  logic              out_full,
  input  logic              out_empty,
  output logic              in_pop_ev,
  output logic              out_push_ev,
  output logic              ovf_set_ev,
  output logic              ovf_clr_ev,
  output logic              cfg_en,
  output logic              ovf_flag,
  output logic              irq,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] rd_next;
  logic              wr_out, wr_cfg;

  assign wr_out      = wen && (addr == OFS_OUT_PUSH);
  assign wr_cfg      = wen && (addr == OFS_IN_CFG);
  assign in_pop_ev   = ren && (addr == OFS_IN_POP) && !in_empty;
  assign out_push_ev = wr_out && !out_full;
  assign ovf_set_ev  = wr_out && out_full;
  assign ovf_clr_ev  = ren && (addr == OFS_OUT_STAT);
  assign irq         = cfg_en && !in_empty;

  always_comb begin
    case (addr)
      OFS_IN_POP,
      OFS_IN_PEEK:  rd_next = head_or_zero(in_empty, in_head);
      OFS_IN_STAT:  rd_next = pack_status(in_full, in_empty, 1'b0);
      OFS_IN_CFG:   rd_next = {{(WORD_W-1){1'b0}}, cfg_en};
      OFS_OUT_STAT: rd_next = pack_status(out_full, out_empty, ovf_flag);
      default:      rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en   <= 1'b0;
      ovf_flag <= 1'b0;
      rdata    <= '0;
    end else begin
      if (wr_cfg) cfg_en <= cfg_wbit;
      ovf_flag <= ovf_set_ev || (ovf_flag && !ovf_clr_ev);
      rdata    <= ren ? rd_next : '0;
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        host_addr,
  input  logic              host_wen,
  input  logic [31:0]       host_wdata,
  input  logic              host_ren,
  output logic [31:0]       host_rdata,
  output logic              host_irq,
  input  logic              rmt_push_valid,
  input  logic [31:0]       rmt_push_data,
  output logic              rmt_push_ready,
  output logic              rmt_pop_valid,
  output logic [31:0]       rmt_pop_data,
  input  logic              rmt_pop_ready
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [WORD_W-1:0] in_head;
  logic [CW-1:0]     in_count, out_count;
  logic              in_full, in_empty, out_full, out_empty;
  logic              in_push_ev, in_pop_ev, out_push_ev, out_pop_ev;
  logic              ovf_set_ev, ovf_clr_ev, cfg_en, ovf_flag;

  assign rmt_push_ready = !in_full;
  assign in_push_ev     = rmt_push_valid && rmt_push_ready;
  assign rmt_pop_valid  = !out_empty;
  assign out_pop_ev     = rmt_pop_valid && rmt_pop_ready;

  mbox_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_in_q (
    .clk(clk), .rst(rst),
    .push(in_push_ev), .wdata(rmt_push_data),
    .pop(in_pop_ev), .head(in_head), .count(in_count),
    .full(in_full), .empty(in_empty)
  );

  mbox_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_out_q (
    .clk(clk), .rst(rst),
    .push(out_push_ev), .wdata(host_wdata),
    .pop(out_pop_ev), .head(rmt_pop_data), .count(out_count),
    .full(out_full), .empty(out_empty)
  );

  mbox_host_regs u_regs (
    .clk(clk), .rst(rst),
    .addr(host_addr), .wen(host_wen), .cfg_wbit(host_wdata[0]), .ren(host_ren),
    .in_head(in_head), .in_full(in_full), .in_empty(in_empty),
    .out_full(out_full), .out_empty(out_empty),
    .in_pop_ev(in_pop_ev), .out_push_ev(out_push_ev),
    .ovf_set_ev(ovf_set_ev), .ovf_clr_ev(ovf_clr_ev),
    .cfg_en(cfg_en), .ovf_flag(ovf_flag), .irq(host_irq), .rdata(host_rdata)
  );
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rst,
  input logic [5:0]    host_addr,
  input logic          host_ren,
  input logic          host_irq,
  input logic          rmt_push_ready,
  input logic          rmt_pop_valid,
  input logic [CW-1:0] in_count,
  input logic [CW-1:0] out_count,
  input logic          in_push_ev,
  input logic          out_pop_ev,
  input logic          ovf_set_ev,
  input logic          ovf_clr_ev,
  input logic          cfg_en,
  input logic          ovf_flag
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $fell(rst) |-> (in_count == '0 && out_count == '0 && !host_irq && !ovf_flag && !cfg_en));

  assert_in_bound_R2: assert property (@(posedge clk) disable iff (rst)
    in_count <= CW'(DEPTH));

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
    (host_ren && host_addr == 6'h00 && in_count == '0 && !in_push_ev) |=> in_count == '0);

  assert_irq_level_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && in_count != '0) |-> host_irq);

  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en || in_count == '0) |-> !host_irq);

  assert_pop_valid_R7: assert property (@(posedge clk) disable iff (rst)
    (out_count != '0) |-> rmt_pop_valid);

  assert_drop_write_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf_set_ev && !out_pop_ev) |=> $stable(out_count));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr_ev) |=> ovf_flag);

  assert_push_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (in_count == CW'(DEPTH)) |-> !rmt_push_ready);
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_ren(host_ren),
  .host_irq(host_irq), .rmt_push_ready(rmt_push_ready), .rmt_pop_valid(rmt_pop_valid),
  .in_count(in_count), .out_count(out_count), .in_push_ev(in_push_ev),
  .out_pop_ev(out_pop_ev), .ovf_set_ev(ovf_set_ev), .ovf_clr_ev(ovf_clr_ev),
  .cfg_en(cfg_en), .ovf_flag(ovf_flag)
);

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
module sim_ipc_mailbox;
  localparam int DEPTH = 8;
  localparam logic [31:0] ST_FULL  = 32'h8000_0000;
  localparam logic [31:0] ST_EMPTY = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  host_addr = '0;
  logic        host_wen = 1'b0, host_ren = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_irq;
  logic        rmt_push_valid = 1'b0;
  logic [31:0] rmt_push_data = '0;
  logic        rmt_push_ready, rmt_pop_valid;
  logic [31:0] rmt_pop_data;
  logic        rmt_pop_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ipc_mailbox #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wen(host_wen),
    .host_wdata(host_wdata), .host_ren(host_ren), .host_rdata(host_rdata),
    .host_irq(host_irq), .rmt_push_valid(rmt_push_valid), .rmt_push_data(rmt_push_data),
    .rmt_push_ready(rmt_push_ready), .rmt_pop_valid(rmt_pop_valid),
    .rmt_pop_data(rmt_pop_data), .rmt_pop_ready(rmt_pop_ready)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic host_rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a; host_ren = 1'b1;
    @(negedge clk); host_ren = 1'b0; d = host_rdata;
  endtask

  task automatic host_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wen = 1'b1;
    @(negedge clk); host_wen = 1'b0;
  endtask

  task automatic rmt_push(logic [31:0] d);
    @(negedge clk); rmt_push_valid = 1'b1; rmt_push_data = d;
    @(negedge clk); rmt_push_valid = 1'b0;
  endtask

  task automatic rmt_pop(string req, logic [31:0] exp);
    @(negedge clk);
    chk(req, {31'd0, rmt_pop_valid}, 32'd1);
    chk(req, rmt_pop_data, exp);
    rmt_pop_ready = 1'b1;
    @(negedge clk); rmt_pop_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    chk("R1 irq", {31'd0, host_irq}, 0);
    chk("R1 pop_valid", {31'd0, rmt_pop_valid}, 0);
    chk("R1 push_ready", {31'd0, rmt_push_ready}, 1);
    host_rd(6'h18, d); chk("R1 R5 in status", d, ST_EMPTY);
    host_rd(6'h38, d); chk("R1 R5 out status", d, ST_EMPTY);
    host_rd(6'h1C, d); chk("R1 cfg", d, 0);
  endtask

  task automatic t_in_order();
    logic [31:0] d;
    rmt_push(32'hA1A1_0001); rmt_push(32'hB2B2_0002); rmt_push(32'hC3C3_0003);
    host_rd(6'h10, d); chk("R4 peek", d, 32'hA1A1_0001);
    host_rd(6'h10, d); chk("R4 peek again", d, 32'hA1A1_0001);
    host_rd(6'h18, d); chk("R5 in status partial", d, 0);
    host_rd(6'h00, d); chk("R2 pop 1", d, 32'hA1A1_0001);
    host_rd(6'h00, d); chk("R2 pop 2", d, 32'hB2B2_0002);
    host_rd(6'h00, d); chk("R2 pop 3", d, 32'hC3C3_0003);
    host_rd(6'h00, d); chk("R3 empty pop", d, 0);
    host_rd(6'h10, d); chk("R4 empty peek", d, 0);
    rmt_push(32'h0000_5555);
    host_rd(6'h00, d); chk("R3 pointers kept", d, 32'h0000_5555);
    host_rd(6'h18, d); chk("R5 in status empty", d, ST_EMPTY);
  endtask

  task automatic t_in_full();
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) rmt_push(32'h1000 + i);
    @(negedge clk); chk("R9 ready low when full", {31'd0, rmt_push_ready}, 0);
    host_rd(6'h18, d); chk("R5 in status full", d, ST_FULL);
    rmt_push(32'hDEAD_BEEF);
    for (int i = 0; i < DEPTH; i++) begin
      host_rd(6'h00, d); chk("R2 R9 drain order", d, 32'h1000 + i);
    end
    host_rd(6'h18, d); chk("R9 extra push not stored", d, ST_EMPTY);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    host_wr(6'h1C, 32'hFFFF_FFFF);
    host_rd(6'h1C, d); chk("R6 cfg readback", d, 1);
    chk("R6 irq idle when empty", {31'd0, host_irq}, 0);
    rmt_push(32'h77);
    chk("R6 irq on data", {31'd0, host_irq}, 1);
    host_wr(6'h1C, 0);
    chk("R6 irq disabled", {31'd0, host_irq}, 0);
    host_wr(6'h1C, 1);
    chk("R6 irq re-enabled", {31'd0, host_irq}, 1);
    host_rd(6'h00, d);
    chk("R6 irq after drain", {31'd0, host_irq}, 0);
    host_wr(6'h1C, 0);
  endtask

  task automatic t_out();
    host_wr(6'h20, 32'h0BAD_0001); host_wr(6'h20, 32'h0BAD_0002); host_wr(6'h20, 32'h0BAD_0003);
    rmt_pop("R7 out 1", 32'h0BAD_0001);
    rmt_pop("R7 out 2", 32'h0BAD_0002);
    rmt_pop("R7 out 3", 32'h0BAD_0003);
    @(negedge clk); chk("R7 valid low when empty", {31'd0, rmt_pop_valid}, 0);
  endtask

  task automatic t_ovf();
    logic [31:0] d;
    for (int i = 0; i < DEPTH + 1; i++) host_wr(6'h20, 32'h2000 + i);
    host_rd(6'h38, d); chk("R8 overflow flag", d, ST_FULL | 32'h1);
    host_rd(6'h38, d); chk("R8 flag cleared by read", d, ST_FULL);
    for (int i = 0; i < DEPTH; i++) rmt_pop("R8 kept words", 32'h2000 + i);
    @(negedge clk); chk("R8 dropped word absent", {31'd0, rmt_pop_valid}, 0);
  endtask

  task automatic t_ro();
    logic [31:0] d;
    rmt_push(32'hFACE_0001);
    host_wr(6'h00, 32'h1111_1111);
    host_wr(6'h10, 32'h2222_2222);
    host_wr(6'h18, 32'hFFFF_FFFF);
    host_wr(6'h38, 32'hFFFF_FFFF);
    host_rd(6'h18, d); chk("R10 in status untouched", d, 0);
    host_rd(6'h38, d); chk("R10 out status untouched", d, ST_EMPTY);
    chk("R10 no outbound word", {31'd0, rmt_pop_valid}, 0);
    host_rd(6'h00, d); chk("R10 head untouched", d, 32'hFACE_0001);
    host_rd(6'h18, d); chk("R10 single word only", d, ST_EMPTY);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_in_order();
    t_in_full();
    t_irq();
    t_out();
    t_ovf();
    t_ro();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule